// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block gathers the four interrupt causes of a character-serial port: receiver line errors, a newly received character, an empty transmit holding register and a change on the modem inputs. Each cause is held in its own pending latch. The latch is set by an event from the surrounding port logic and cleared by the register access that services it. An enable register decides which causes may interrupt the processor.

The enabled pending cause of highest priority is reported as an 8-bit identification value. Bits 3 to 1 hold a 3-bit code, and bit 0 is low while an interrupt is pending. A single interrupt line is driven high while any enabled cause is pending. A freeze input silences the line and the identification value for debug halts. It does this without losing any latched cause.

The line-status, receiver, transmitter and modem logic that produce the events sit outside the block. They drive single-cycle strobes into it. All inputs are sampled on the rising clock edge. Latched state reaches the outputs in the cycle after the edge that captured it.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable register bit 0 enables received-data, bit 1 transmit-empty, bit 2 line-status and bit 3 modem-status interrupts; a write stores all eight bits but bits 7..4 always read back 0; the register resets to 0.
- R2: Among enabled pending causes the identification code (bits 3..1) is 3'b011 for line status (highest), 3'b010 for received data, 3'b001 for transmit empty and 3'b000 for modem status (lowest).
- R3: Identification bit 0 is 0 when an enabled cause is pending and 1 otherwise; bits 7..4 always read 0; with nothing pending the value is 8'h01, which is also the value after reset.
- R4: The code 3'b110 is never produced.
- R5: While freeze is high the interrupt output is 0 and the identification value is 8'h01; latched causes are kept and reappear when freeze falls.
- R6: The line-status cause is set by a pulse on any of the four error inputs (overrun, parity, framing, break) and cleared by a line-status read.
- R7: The received-data cause is set by a character-received pulse and cleared by a receive-buffer read.
- R8: The transmit-empty cause is set when the holding-register-empty input rises and cleared by a holding-register write.
- R9: An identification read clears the transmit-empty cause only when the value it returns carries code 3'b001 with bit 0 low.
- R10: Writing the enable register so that bit 1 goes from 0 to 1 while the holding register is empty sets the transmit-empty cause; the same write while it is not empty does not.
- R11: The modem-status cause is set by a modem-change pulse and cleared by a modem-status read.
- R12: The interrupt output is 1 exactly when some enabled cause is pending and freeze is 0.
- R13: When a set and a clear of the same cause arrive in one cycle, the cause is left pending.
- R14: A disabled cause still latches; it is absent from the identification value until its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Debug freeze; masks all interrupts |
| enWrite | input | 1 | Write strobe for the enable register |
| enWrData | input | 8 | Data for the enable register |
| identRead | input | 1 | Identification register read strobe |
| lsRead | input | 1 | Line-status read strobe |
| rbrRead | input | 1 | Receive-buffer read strobe |
| msrRead | input | 1 | Modem-status read strobe |
| thrWrite | input | 1 | Transmit holding register write strobe |
| lineErr | input | 4 | Error event pulses: overrun, parity, framing, break |
| rxDone | input | 1 | Character-received pulse |
| thrEmpty | input | 1 | Transmit holding register empty level |
| msDelta | input | 1 | Modem input change pulse |
| enableValue | output | 8 | Enable register read value |
| identValue | output | 8 | Identification register read value |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong pending latch shows on the outputs in the cycle after the event or access that corrupted it. It appears as an identification code that does not match the priority of the enabled pending causes, or as an interrupt line that disagrees with bit 0. Pending state hidden by a clear enable bit or by freeze stays invisible until the mask opens. For this reason the sweep sets every mix of causes under every enable mask and compares both outputs one cycle later. The transmit-empty clear rules depend on the code returned at the moment of the read. They are therefore exercised with a higher-priority cause both present and absent.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int ERR_W   = 4;
  localparam int REG_W   = 8;

  // source index equals enable bit position
  localparam int SRC_RX   = 0;
  localparam int SRC_THRE = 1;
  localparam int SRC_LS   = 2;
  localparam int SRC_MS   = 3;

  localparam logic [2:0] CODE_LS   = 3'b011;
  localparam logic [2:0] CODE_RX   = 3'b010;
  localparam logic [2:0] CODE_THRE = 3'b001;
  localparam logic [2:0] CODE_MS   = 3'b000;

  typedef struct packed {
    logic [NUM_SRC-1:0] setSrc;
    logic [NUM_SRC-1:0] clrSrc;
  } irqStrobes_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enWrite,
  input  logic [REG_W-1:0] enWrData,
  input  logic [REG_W-1:0] enableValue,
  input  logic [REG_W-1:0] identValue,
  input  logic             identRead,
  input  logic             lsRead,
  input  logic             rbrRead,
  input  logic             msrRead,
  input  logic             thrWrite,
  input  logic [ERR_W-1:0] lineErr,
  input  logic             rxDone,
  input  logic             thrEmpty,
  input  logic             msDelta,
  output irqStrobes_t      strobes
);
  localparam logic [REG_W-1:0] THRE_IDENT = {{(REG_W-4){1'b0}}, CODE_THRE, 1'b0};

  logic thrEmptyPrev;
  logic thrEmptyRise;
  logic threEnRise;
  logic identIsThre;

  // starts high: the holding register is empty after reset and must not
  // raise a cause on its own
  always_ff @(posedge clk) begin
    if (rst) thrEmptyPrev <= 1'b1;
    else     thrEmptyPrev <= thrEmpty;
  end

  always_comb begin
    thrEmptyRise = thrEmpty && !thrEmptyPrev;
    threEnRise   = enWrite && enWrData[SRC_THRE] && !enableValue[SRC_THRE] && thrEmpty;
    identIsThre  = identRead && (identValue == THRE_IDENT);

    strobes.setSrc[SRC_LS]   = |lineErr;
    strobes.clrSrc[SRC_LS]   = lsRead;
    strobes.setSrc[SRC_RX]   = rxDone;
    strobes.clrSrc[SRC_RX]   = rbrRead;
    strobes.setSrc[SRC_THRE] = thrEmptyRise || threEnRise;
    strobes.clrSrc[SRC_THRE] = thrWrite || identIsThre;
    strobes.setSrc[SRC_MS]   = msDelta;
    strobes.clrSrc[SRC_MS]   = msrRead;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             enWrite,
  input  logic [REG_W-1:0] enWrData,
  input  irqStrobes_t      strobes,
  output logic [REG_W-1:0] enableValue,
  output logic [REG_W-1:0] identValue,
  output logic             irq
);
  logic [NUM_SRC-1:0] enBits;
  logic [NUM_SRC-1:0] pendBits;
  logic [NUM_SRC-1:0] activeBits;
  logic [2:0]         code;

  always_ff @(posedge clk) begin
    if (rst)          enBits <= '0;
    else if (enWrite) enBits <= enWrData[NUM_SRC-1:0];
  end

  // one latch per cause; a set in the same cycle as a clear wins
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)                    pendBits[i] <= 1'b0;
      else if (strobes.setSrc[i]) pendBits[i] <= 1'b1;
      else if (strobes.clrSrc[i]) pendBits[i] <= 1'b0;
    end
  end

  always_comb begin
    activeBits = freeze ? '0 : (pendBits & enBits);
    if      (activeBits[SRC_LS])   code = CODE_LS;
    else if (activeBits[SRC_RX])   code = CODE_RX;
    else if (activeBits[SRC_THRE]) code = CODE_THRE;
    else                           code = CODE_MS;
    irq         = |activeBits;
    identValue  = {{(REG_W-4){1'b0}}, irq ? code : 3'b000, !irq};
    enableValue = {{(REG_W-NUM_SRC){1'b0}}, enBits};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       freeze,
  input  logic       enWrite,
  input  logic [7:0] enWrData,
  input  logic       identRead,
  input  logic       lsRead,
  input  logic       rbrRead,
  input  logic       msrRead,
  input  logic       thrWrite,
  input  logic [3:0] lineErr,
  input  logic       rxDone,
  input  logic       thrEmpty,
  input  logic       msDelta,
  output logic [7:0] enableValue,
  output logic [7:0] identValue,
  output logic       irq
);
  irqStrobes_t strobes;

  uart_irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .enWrite(enWrite), .enWrData(enWrData),
    .enableValue(enableValue), .identValue(identValue), .identRead(identRead),
    .lsRead(lsRead), .rbrRead(rbrRead), .msrRead(msrRead), .thrWrite(thrWrite),
    .lineErr(lineErr), .rxDone(rxDone), .thrEmpty(thrEmpty), .msDelta(msDelta),
    .strobes(strobes)
  );

  uart_irq_dp u_dp (
    .clk(clk), .rst(rst), .freeze(freeze), .enWrite(enWrite), .enWrData(enWrData),
    .strobes(strobes), .enableValue(enableValue), .identValue(identValue), .irq(irq)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       freeze,
  input logic       enWrite,
  input logic       lsRead,
  input logic       rbrRead,
  input logic       msrRead,
  input logic       thrWrite,
  input logic [3:0] lineErr,
  input logic       rxDone,
  input logic       thrEmpty,
  input logic       msDelta,
  input logic [7:0] enableValue,
  input logic [7:0] identValue,
  input logic       irq
);
  a_r4_no_timeout_code: assert property (@(posedge clk) disable iff (rst)
    identValue[3:1] != 3'b110);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    identValue[7:4] == 4'h0);

  a_r1_enable_upper_zero: assert property (@(posedge clk) disable iff (rst)
    enableValue[7:4] == 4'h0);

  a_r5_freeze_quiet: assert property (@(posedge clk) disable iff (rst)
    freeze |-> (!irq && identValue == 8'h01));

  a_r12_irq_vs_pending: assert property (@(posedge clk) disable iff (rst)
    irq == !identValue[0]);

  a_r6_ls_cleared: assert property (@(posedge clk) disable iff (rst)
    (lsRead && lineErr == 4'h0) |=> (identValue[3:1] != 3'b011 || identValue[0]));

  a_r7_rx_cleared: assert property (@(posedge clk) disable iff (rst)
    (rbrRead && !rxDone) |=> (identValue[3:1] != 3'b010 || identValue[0]));

  a_r8_thr_write_clears: assert property (@(posedge clk) disable iff (rst)
    (thrWrite && !thrEmpty && !enWrite) |=> (identValue[3:1] != 3'b001 || identValue[0]));

  a_r11_ms_cleared: assert property (@(posedge clk) disable iff (rst)
    (msrRead && !msDelta && lsRead && rbrRead && thrWrite && !thrEmpty &&
     !enWrite && lineErr == 4'h0 && !rxDone) |=> identValue[0]);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk (
  .clk(clk), .rst(rst), .freeze(freeze), .enWrite(enWrite), .lsRead(lsRead),
  .rbrRead(rbrRead), .msrRead(msrRead), .thrWrite(thrWrite), .lineErr(lineErr),
  .rxDone(rxDone), .thrEmpty(thrEmpty), .msDelta(msDelta),
  .enableValue(enableValue), .identValue(identValue), .irq(irq)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       freeze = 1'b0;
  logic       enWrite = 1'b0;
  logic [7:0] enWrData = 8'h00;
  logic       identRead = 1'b0;
  logic       lsRead = 1'b0;
  logic       rbrRead = 1'b0;
  logic       msrRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic [3:0] lineErr = 4'h0;
  logic       rxDone = 1'b0;
  logic       thrEmpty = 1'b1;
  logic       msDelta = 1'b0;
  logic [7:0] enableValue;
  logic [7:0] identValue;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .freeze(freeze), .enWrite(enWrite), .enWrData(enWrData),
    .identRead(identRead), .lsRead(lsRead), .rbrRead(rbrRead), .msrRead(msrRead),
    .thrWrite(thrWrite), .lineErr(lineErr), .rxDone(rxDone), .thrEmpty(thrEmpty),
    .msDelta(msDelta), .enableValue(enableValue), .identValue(identValue), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // pend order: [0] rx, [1] transmit empty, [2] line status, [3] modem
  function automatic logic [7:0] expIdent(input logic [3:0] mask, input logic [3:0] pend,
                                          input logic frz);
    logic [3:0] eff;
    eff = mask & pend;
    if (frz || eff == 4'h0) return 8'h01;
    if (eff[2]) return 8'h06;
    if (eff[0]) return 8'h04;
    if (eff[1]) return 8'h02;
    return 8'h00;
  endfunction

  task automatic writeEnable(input logic [7:0] v);
    enWrite = 1'b1; enWrData = v; tick(); enWrite = 1'b0;
  endtask

  task automatic clearAll();
    thrEmpty = 1'b0;
    lsRead = 1'b1; rbrRead = 1'b1; msrRead = 1'b1; thrWrite = 1'b1;
    tick();
    lsRead = 1'b0; rbrRead = 1'b0; msrRead = 1'b0; thrWrite = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();
    // R3 reset state, R1 reset enable
    check("R3 reset ident", identValue, 8'h01);
    check("R1 reset enable", enableValue, 8'h00);
    check("R12 reset irq", {7'd0, irq}, 8'h00);

    // R1 upper bits read zero
    writeEnable(8'hF5);
    check("R1 enable readback", enableValue, 8'h05);
    writeEnable(8'h00);

    // Sweep: every enable mask against every mix of causes (R2, R12, R14, R5)
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        thrEmpty = 1'b0;
        enWrite = 1'b1; enWrData = 8'(m);
        tick();
        enWrite = 1'b0;
        clearAll();
        lineErr = p[2] ? (4'h1 << (p % 4)) : 4'h0;
        rxDone = p[0]; msDelta = p[3]; thrEmpty = p[1];
        tick();
        lineErr = 4'h0; rxDone = 1'b0; msDelta = 1'b0;
        check("R2 R14 ident sweep", identValue, expIdent(4'(m), 4'(p), 1'b0));
        check("R12 irq sweep", {7'd0, irq}, {7'd0, ((m & p) != 0)});
        freeze = 1'b1; #1;
        check("R5 freeze ident", identValue, 8'h01);
        check("R5 freeze irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        freeze = 1'b0; #1;
        check("R5 after freeze", identValue, expIdent(4'(m), 4'(p), 1'b0));
        @(negedge clk);
      end
    end

    // R6: each error input alone, then line-status read clears
    writeEnable(8'h0F);
    for (int b = 0; b < 4; b++) begin
      clearAll();
      lineErr = 4'h1 << b; tick(); lineErr = 4'h0;
      check("R6 error bit sets", identValue, 8'h06);
      lsRead = 1'b1; tick(); lsRead = 1'b0;
      check("R6 read clears", identValue, 8'h01);
    end

    // R7
    clearAll();
    rxDone = 1'b1; tick(); rxDone = 1'b0;
    check("R7 rx set", identValue, 8'h04);
    rbrRead = 1'b1; tick(); rbrRead = 1'b0;
    check("R7 rx clear", identValue, 8'h01);

    // R8
    clearAll();
    thrEmpty = 1'b1; tick();
    check("R8 empty rise", identValue, 8'h02);
    thrWrite = 1'b1; thrEmpty = 1'b0; tick(); thrWrite = 1'b0;
    check("R8 write clears", identValue, 8'h01);

    // R9: ident read returning line status leaves transmit-empty pending
    clearAll();
    thrEmpty = 1'b1; lineErr = 4'h2; tick(); lineErr = 4'h0;
    identRead = 1'b1; tick(); identRead = 1'b0;
    check("R9 other code read", identValue, 8'h06);
    lsRead = 1'b1; tick(); lsRead = 1'b0;
    check("R9 thre still pending", identValue, 8'h02);
    identRead = 1'b1; tick(); identRead = 1'b0;
    check("R9 thre read clears", identValue, 8'h01);

    // R10: enable rise while empty sets, while not empty does not
    writeEnable(8'h00);
    clearAll();
    thrEmpty = 1'b1; tick();
    thrWrite = 1'b1; tick(); thrWrite = 1'b0;   // clear while still empty
    check("R10 disabled quiet", identValue, 8'h01);
    writeEnable(8'h02);
    check("R10 enable rise sets", identValue, 8'h02);
    writeEnable(8'h00);
    clearAll();
    writeEnable(8'h02);
    check("R10 not empty no set", identValue, 8'h01);

    // R11
    writeEnable(8'h08);
    clearAll();
    msDelta = 1'b1; tick(); msDelta = 1'b0;
    check("R11 ms set", identValue, 8'h00);
    msrRead = 1'b1; tick(); msrRead = 1'b0;
    check("R11 ms clear", identValue, 8'h01);

    // R13: set and clear together leave the cause pending
    writeEnable(8'h0D);
    clearAll();
    msDelta = 1'b1; msrRead = 1'b1; tick(); msDelta = 1'b0; msrRead = 1'b0;
    check("R13 ms set wins", identValue, 8'h00);
    rxDone = 1'b1; rbrRead = 1'b1; tick(); rxDone = 1'b0; rbrRead = 1'b0;
    check("R13 rx set wins", identValue, 8'h04);
    lineErr = 4'h8; lsRead = 1'b1; tick(); lineErr = 4'h0; lsRead = 1'b0;
    check("R13 ls set wins", identValue, 8'h06);

    // R14: latched while masked, shown once enabled; R4 never timeout code
    writeEnable(8'h00);
    clearAll();
    rxDone = 1'b1; tick(); rxDone = 1'b0;
    check("R14 masked", identValue, 8'h01);
    writeEnable(8'h01);
    check("R14 unmasked", identValue, 8'h04);
    check("R4 no timeout code", {5'd0, identValue[3:1]} == 8'h06 ? 8'h01 : 8'h00, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule